// File: doc/BRIEF.md
# Serial Input Interrupt Detector

This block turns the sampled input bits of a serial pin expander into interrupts. The shifting logic upstream collects one input word per scan. It delivers that word on `frame_in` together with a one-cycle `frame_valid` strobe. The word holds only the input half of each pin pair, because output pins never raise interrupts.

On every strobe, each input bit is compared with its value in the previous scan. A three-bit trigger setting per pin selects what counts as an event:
- a falling edge,
- a rising edge,
- either edge,
- a high level,
- a low level.

An event sets a sticky per-pin flag. Software clears a flag by writing a one to it. A separate per-pin enable decides whether a set flag reaches the single interrupt line. That line is shared by all banks.

Software reaches the settings through a small word-addressed register port. Each bank of pins has five registers: enable, polarity, level select, dual-edge select and flags.

Top module: `sirq_hub`

## Requirements
- R1: While reset is active and after reset, every enable, polarity, level-select, dual-edge and flag register of every bank reads 0, and `irq` is 0.
- R2: The word address is {bank, slot}, with the slot in the low 3 bits. The slots are:
  - slot 0: enable (byte offset 0x0)
  - slot 1: polarity (0x4)
  - slot 2: level select (0x8)
  - slot 3: dual-edge select (0xC)
  - slot 4: flags (0x10)

  Writes to slots 0 to 3 take effect at the next clock edge and read back unchanged. Slots 5 to 7 read 0, and writes to them change nothing.
- R3: With level select 0 and dual-edge 0, a pin flags a falling edge when polarity is 0 and a rising edge when polarity is 1. An edge means the bit differs between the previous strobed frame and the current one, in that direction.
- R4: With level select 0 and dual-edge 1, any change of the bit between consecutive strobed frames sets the flag, whatever the polarity.
- R5: With level select 1, every strobe on which the bit equals the polarity value sets the flag, whatever the dual-edge bit. This holds again on the strobe after a clear while the level persists.
- R6: The first strobe after reset has no previous frame, so it can raise no edge event; level events are still detected.
- R7: Inputs are evaluated only in cycles with `frame_valid` high. Flags never rise in other cycles, however `frame_in` moves. Configuration written in the same cycle as a strobe applies from the next strobe.
- R8: Writing the flags slot clears exactly the flag bits written as 1 in that bank. Bits written 0 and other banks keep their value.
- R9: When a clearing write and a new event hit the same flag bit in one cycle, the flag stays set.
- R10: Flags are set regardless of the enable bits. `irq` is high exactly when some bank has a flag bit whose enable bit is 1, and it follows the registers with no further delay in the default configuration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_valid | input | 1 | One-cycle strobe marking a complete input frame |
| frame_in | input | NBANK*BANK_W | Input bits of all banks, bank 0 in the lowest bits |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | BIDX_W+3 | Word address {bank, slot} |
| reg_wdata | input | BANK_W | Register write data |
| reg_rdata | output | BANK_W | Register read data for `reg_addr`, combinational |
| irq | output | 1 | Combined interrupt of all banks |

## Verification
The bench goes after four corner cases:
- **First strobe after reset.** A design that compares against a zero history would flag false rising edges here.
- **Input motion between strobes.** A design that samples continuously would latch flags in those cycles.
- **Level triggers after a clear.** A design that treats levels as one-shot would leave the flag low after software clears it.
- **A clear colliding with a new event.** A clear-priority design would silently drop the new event.

The bench also writes zeros and single bits to the flag slot, and writes the unmapped slots. Either kind of write, if decoded wrongly, would wipe unrelated flags or configuration.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

   localparam int unsigned SLOT_W = 3;

   typedef enum logic [SLOT_W-1:0] {
      SLOT_ENA  = 3'd0,
      SLOT_POL  = 3'd1,
      SLOT_LVL  = 3'd2,
      SLOT_DUAL = 3'd3,
      SLOT_FLAG = 3'd4
   } slot_e;

   typedef struct packed {
      logic pol;
      logic lvl;
      logic dual;
   } trig_cfg_t;

   // Event decision for one pin; primed is 0 until a history frame exists.
   function automatic logic trig_hit(input trig_cfg_t cfg, input logic cur,
                                     input logic prv, input logic primed);
      logic res;
      if (cfg.lvl)
         res = cfg.pol ? cur : ~cur;
      else if (!primed)
         res = 1'b0;
      else if (cfg.dual)
         res = cur ^ prv;
      else if (cfg.pol)
         res = cur & ~prv;
      else
         res = ~cur & prv;
      return res;
   endfunction

endpackage

// File: rtl/sirq_frame_hist.sv
module sirq_frame_hist #(
   parameter int unsigned TW = 128
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          strobe,
   input  logic [TW-1:0] frame,
   output logic [TW-1:0] prv,
   output logic          primed
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prv    <= '0;
         primed <= 1'b0;
      end else if (strobe) begin
         prv    <= frame;
         primed <= 1'b1;
      end
   end
endmodule

// File: rtl/sirq_pin_eval.sv
module sirq_pin_eval
   import sirq_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  logic         strobe,
   input  logic         primed,
   input  logic [W-1:0] cur,
   input  logic [W-1:0] prv,
   input  logic [W-1:0] pol,
   input  logic [W-1:0] lvl,
   input  logic [W-1:0] dual,
   output logic [W-1:0] hit
);
   for (genvar i = 0; i < W; i++) begin : g_pin
      trig_cfg_t cfg;
      assign cfg    = '{pol: pol[i], lvl: lvl[i], dual: dual[i]};
      assign hit[i] = strobe & trig_hit(cfg, cur[i], prv[i], primed);
   end
endmodule

// File: rtl/sirq_bank_regs.sv
module sirq_bank_regs
   import sirq_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_sel,
   input  slot_e        slot,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] hit,
   output logic [W-1:0] ena,
   output logic [W-1:0] pol,
   output logic [W-1:0] lvl,
   output logic [W-1:0] dual,
   output logic [W-1:0] flag
);
   logic [W-1:0] clr;

   assign clr = (wr_sel && slot == SLOT_FLAG) ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ena  <= '0;
         pol  <= '0;
         lvl  <= '0;
         dual <= '0;
      end else if (wr_sel) begin
         case (slot)
            SLOT_ENA:  ena  <= wdata;
            SLOT_POL:  pol  <= wdata;
            SLOT_LVL:  lvl  <= wdata;
            SLOT_DUAL: dual <= wdata;
            default: ;
         endcase
      end
   end

   // A new event outranks a clear aimed at the same bit.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag <= '0;
      else        flag <= (flag & ~clr) | hit;
   end
endmodule

// File: rtl/sirq_irq_merge.sv
module sirq_irq_merge #(
   parameter int unsigned NB = 4,
   parameter int unsigned W  = 32
) (
   input  logic [NB*W-1:0] flag_all,
   input  logic [NB*W-1:0] ena_all,
   output logic            pending
);
   logic [NB-1:0] bank_pend;

   for (genvar b = 0; b < NB; b++) begin : g_bank
      assign bank_pend[b] = |(flag_all[b*W +: W] & ena_all[b*W +: W]);
   end

   assign pending = |bank_pend;
endmodule

// File: rtl/sirq_hub.sv
module sirq_hub
   import sirq_pkg::*;
#(
   parameter  int unsigned NBANK   = 4,
   parameter  int unsigned BANK_W  = 32,
   parameter  bit          IRQ_REG = 1'b0,
   localparam int unsigned BIDX_W  = (NBANK > 1) ? $clog2(NBANK) : 1,
   localparam int unsigned ADDR_W  = BIDX_W + SLOT_W,
   localparam int unsigned FRAME_W = NBANK * BANK_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frame_valid,
   input  logic [FRAME_W-1:0] frame_in,
   input  logic               reg_wr,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [BANK_W-1:0]  reg_wdata,
   output logic [BANK_W-1:0]  reg_rdata,
   output logic               irq
);
   if (BANK_W < 1 || BANK_W > 32) begin : g_bad_width
      $error("sirq_hub: BANK_W must lie in 1..32");
   end
   if (NBANK < 1 || NBANK > 64) begin : g_bad_banks
      $error("sirq_hub: NBANK must lie in 1..64");
   end

   slot_e             slot;
   logic              slot_ok;
   logic [BIDX_W-1:0] bank_idx;
   logic [FRAME_W-1:0] prev_frame;
   logic               primed;
   logic [FRAME_W-1:0] flag_all;
   logic [FRAME_W-1:0] ena_all;
   logic [BANK_W-1:0]  rd_bank [NBANK];
   logic               pending;

   assign slot     = slot_e'(reg_addr[SLOT_W-1:0]);
   assign slot_ok  = reg_addr[SLOT_W-1:0] <= 3'd4;
   assign bank_idx = reg_addr[ADDR_W-1:SLOT_W];

   sirq_frame_hist #(.TW(FRAME_W)) u_hist (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (frame_valid),
      .frame  (frame_in),
      .prv    (prev_frame),
      .primed (primed)
   );

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic [BANK_W-1:0] ena, pol, lvl, dual, flag, hit;
      logic              wr_sel;

      assign wr_sel = reg_wr && slot_ok && (bank_idx == BIDX_W'(b));

      sirq_pin_eval #(.W(BANK_W)) u_eval (
         .strobe (frame_valid),
         .primed (primed),
         .cur    (frame_in[b*BANK_W +: BANK_W]),
         .prv    (prev_frame[b*BANK_W +: BANK_W]),
         .pol    (pol),
         .lvl    (lvl),
         .dual   (dual),
         .hit    (hit)
      );

      sirq_bank_regs #(.W(BANK_W)) u_regs (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_sel (wr_sel),
         .slot   (slot),
         .wdata  (reg_wdata),
         .hit    (hit),
         .ena    (ena),
         .pol    (pol),
         .lvl    (lvl),
         .dual   (dual),
         .flag   (flag)
      );

      assign flag_all[b*BANK_W +: BANK_W] = flag;
      assign ena_all[b*BANK_W +: BANK_W]  = ena;

      always_comb begin
         case (slot)
            SLOT_ENA:  rd_bank[b] = ena;
            SLOT_POL:  rd_bank[b] = pol;
            SLOT_LVL:  rd_bank[b] = lvl;
            SLOT_DUAL: rd_bank[b] = dual;
            SLOT_FLAG: rd_bank[b] = flag;
            default:   rd_bank[b] = '0;
         endcase
      end
   end

   always_comb begin
      reg_rdata = '0;
      for (int b = 0; b < NBANK; b++) begin
         if (bank_idx == BIDX_W'(b)) reg_rdata = rd_bank[b];
      end
   end

   sirq_irq_merge #(.NB(NBANK), .W(BANK_W)) u_merge (
      .flag_all (flag_all),
      .ena_all  (ena_all),
      .pending  (pending)
   );

   if (IRQ_REG) begin : g_irq_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= pending;
      end
   end else begin : g_irq_comb
      assign irq = pending;
   end
endmodule

// File: rtl/sirq_hub_chk.sv
module sirq_hub_chk #(
   parameter  int unsigned NBANK   = 4,
   parameter  int unsigned BANK_W  = 32,
   parameter  bit          IRQ_REG = 1'b0,
   localparam int unsigned BIDX_W  = (NBANK > 1) ? $clog2(NBANK) : 1,
   localparam int unsigned ADDR_W  = BIDX_W + 3,
   localparam int unsigned FRAME_W = NBANK * BANK_W
) (
   input logic               clk,
   input logic               rst_n,
   input logic               frame_valid,
   input logic               reg_wr,
   input logic [ADDR_W-1:0]  reg_addr,
   input logic [BANK_W-1:0]  reg_wdata,
   input logic [FRAME_W-1:0] flag_all,
   input logic [FRAME_W-1:0] ena_all,
   input logic               irq
);
   logic               wr_flag;
   logic [FRAME_W-1:0] clr_mask;

   assign wr_flag = reg_wr && (reg_addr[2:0] == 3'd4);

   always_comb begin
      clr_mask = '0;
      for (int b = 0; b < NBANK; b++) begin
         if (wr_flag && reg_addr[ADDR_W-1:3] == BIDX_W'(b))
            clr_mask[b*BANK_W +: BANK_W] = reg_wdata;
      end
   end

   a_r1_reset_clean: assert property (@(posedge clk)
      !rst_n |-> (flag_all == '0 && ena_all == '0 && !irq));

   a_r7_rise_only_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_valid |=> ((flag_all & ~$past(flag_all)) == '0));

   a_r8_clear_exact: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_flag && !frame_valid) |=> (flag_all == ($past(flag_all) & ~$past(clr_mask))));

   if (IRQ_REG) begin : g_chk_reg
      a_r10_irq_tracks: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (irq == $past(|(flag_all & ena_all))));
   end else begin : g_chk_comb
      a_r10_irq_tracks: assert property (@(posedge clk) disable iff (!rst_n)
         irq == |(flag_all & ena_all));
   end
endmodule

bind sirq_hub sirq_hub_chk #(
   .NBANK   (NBANK),
   .BANK_W  (BANK_W),
   .IRQ_REG (IRQ_REG)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .frame_valid (frame_valid),
   .reg_wr      (reg_wr),
   .reg_addr    (reg_addr),
   .reg_wdata   (reg_wdata),
   .flag_all    (flag_all),
   .ena_all     (ena_all),
   .irq         (irq)
);

// File: tb/sim_sirq_hub.sv
module sim_sirq_hub;
   localparam int NB = 4;
   localparam int W  = 32;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           fv = 1'b0;
   logic [NB*W-1:0] frm = '0;
   logic           wr = 1'b0;
   logic [4:0]     addr = '0;
   logic [W-1:0]   wdata = '0;
   logic [W-1:0]   rdata;
   logic           irq;

   int total = 0;
   int bad   = 0;

   // reference state
   logic [W-1:0]    m_ena [NB];
   logic [W-1:0]    m_pol [NB];
   logic [W-1:0]    m_lvl [NB];
   logic [W-1:0]    m_dual[NB];
   logic [W-1:0]    m_flag[NB];
   logic [NB*W-1:0] m_prev;
   bit              m_primed;

   always #10 clk = ~clk;

   sirq_hub u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_valid (fv),
      .frame_in    (frm),
      .reg_wr      (wr),
      .reg_addr    (addr),
      .reg_wdata   (wdata),
      .reg_rdata   (rdata),
      .irq         (irq)
   );

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic model_irq();
      logic r = 1'b0;
      for (int b = 0; b < NB; b++) if ((m_flag[b] & m_ena[b]) != 0) r = 1'b1;
      return r;
   endfunction

   function automatic logic [W-1:0] model_reg(input int b, input int s);
      case (s)
         0: return m_ena[b];
         1: return m_pol[b];
         2: return m_lvl[b];
         3: return m_dual[b];
         4: return m_flag[b];
         default: return '0;
      endcase
   endfunction

   task automatic model_step();
      int bk = int'(addr[4:3]);
      int sl = int'(addr[2:0]);
      for (int b = 0; b < NB; b++) begin
         logic [W-1:0] hits = '0;
         logic [W-1:0] clr  = '0;
         if (fv) begin
            for (int i = 0; i < W; i++) begin
               logic c = frm[b*W+i];
               logic p = m_prev[b*W+i];
               logic h;
               if (m_lvl[b][i])        h = m_pol[b][i] ? c : !c;
               else if (!m_primed)     h = 1'b0;
               else if (m_dual[b][i])  h = (c != p);
               else if (m_pol[b][i])   h = c && !p;
               else                    h = !c && p;
               hits[i] = h;
            end
         end
         if (wr && bk == b && sl == 4) clr = wdata;
         m_flag[b] = (m_flag[b] & ~clr) | hits;
         if (wr && bk == b) begin
            case (sl)
               0: m_ena[b]  = wdata;
               1: m_pol[b]  = wdata;
               2: m_lvl[b]  = wdata;
               3: m_dual[b] = wdata;
               default: ;
            endcase
         end
      end
      if (fv) begin
         m_prev   = frm;
         m_primed = 1'b1;
      end
   endtask

   // one clock: drive, let the edge pass, update model, compare at negedge
   task automatic tick(input bit v, input bit w, input int b, input int s, input logic [W-1:0] d);
      fv = v; wr = w; addr = 5'((b << 3) | s); wdata = d;
      @(posedge clk);
      model_step();
      @(negedge clk);
      fv = 1'b0; wr = 1'b0;
      chk("R10 irq per cycle", {31'b0, irq}, {31'b0, model_irq()});
   endtask

   task automatic wreg(input int b, input int s, input logic [W-1:0] d);
      tick(1'b0, 1'b1, b, s, d);
   endtask

   task automatic strobe();
      tick(1'b1, 1'b0, 0, 0, '0);
   endtask

   task automatic rd(input string tag, input int b, input int s, input logic [W-1:0] exp);
      wr = 1'b0; addr = 5'((b << 3) | s);
      #1;
      chk(tag, rdata, exp);
      chk({tag, " model"}, rdata, model_reg(b, s));
   endtask

   task automatic set_bank(input int b, input logic [W-1:0] v);
      frm[b*W +: W] = v;
   endtask

   initial begin
      for (int b = 0; b < NB; b++) begin
         m_ena[b] = '0; m_pol[b] = '0; m_lvl[b] = '0; m_dual[b] = '0; m_flag[b] = '0;
      end
      m_prev = '0; m_primed = 1'b0;

      repeat (2) @(negedge clk);
      // R1: values during reset
      chk("R1 irq in reset", {31'b0, irq}, 32'd0);
      rd("R1 flag in reset", 2, 4, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      for (int b = 0; b < NB; b++)
         for (int s = 0; s < 5; s++) rd("R1 reset value", b, s, 32'h0);
      chk("R1 irq after reset", {31'b0, irq}, 32'd0);

      // R2: map and unmapped slots
      wreg(1, 0, 32'hA5A50F0F);
      wreg(2, 1, 32'h12345678);
      wreg(3, 3, 32'h0000FFFF);
      wreg(0, 2, 32'h00000001);
      rd("R2 enable slot", 1, 0, 32'hA5A50F0F);
      rd("R2 polarity slot", 2, 1, 32'h12345678);
      rd("R2 dual slot", 3, 3, 32'h0000FFFF);
      rd("R2 level slot", 0, 2, 32'h00000001);
      wreg(1, 6, 32'hFFFFFFFF);
      wreg(1, 5, 32'hFFFFFFFF);
      rd("R2 slot5 reads 0", 1, 5, 32'h0);
      rd("R2 slot6 reads 0", 1, 6, 32'h0);
      rd("R2 unmapped write ignored", 1, 0, 32'hA5A50F0F);
      rd("R2 unmapped write ignored", 1, 4, 32'h0);
      wreg(1, 0, 32'h0);
      wreg(2, 1, 32'h0);
      wreg(3, 3, 32'h0);
      wreg(0, 2, 32'h0);

      // R6: bank0 rising; first strobe after reset has no history
      wreg(0, 1, 32'hFFFFFFFF);
      set_bank(0, 32'hFFFFFFFF);
      strobe();
      rd("R6 no edge on first frame", 0, 4, 32'h0);

      // R3: single edges
      set_bank(0, 32'hFFFF0000);
      strobe();
      rd("R3 falling ignored in rising mode", 0, 4, 32'h0);
      set_bank(0, 32'hFFFFFFFF);
      set_bank(1, 32'h000000FF);
      strobe();
      rd("R3 rising edge", 0, 4, 32'h0000FFFF);
      rd("R3 rising ignored in falling mode", 1, 4, 32'h0);
      set_bank(1, 32'h0);
      strobe();
      rd("R3 falling edge", 1, 4, 32'h000000FF);
      wreg(0, 4, 32'hFFFFFFFF);
      wreg(1, 4, 32'hFFFFFFFF);
      rd("R8 full clear bank0", 0, 4, 32'h0);
      rd("R8 full clear bank1", 1, 4, 32'h0);

      // R4: both edges
      wreg(2, 3, 32'hFFFFFFFF);
      wreg(2, 1, 32'h0F0F0F0F);
      set_bank(2, 32'h000000F0);
      strobe();
      rd("R4 dual rise", 2, 4, 32'h000000F0);
      wreg(2, 4, 32'hFFFFFFFF);
      set_bank(2, 32'h00000000);
      strobe();
      rd("R4 dual fall", 2, 4, 32'h000000F0);
      wreg(2, 4, 32'hFFFFFFFF);
      set_bank(2, 32'h00000003);
      strobe();
      rd("R4 dual polarity ignored", 2, 4, 32'h00000003);
      wreg(2, 4, 32'hFFFFFFFF);

      // R5: levels
      wreg(3, 2, 32'hFFFFFFFF);
      wreg(3, 1, 32'h0000FFFF);
      wreg(3, 3, 32'hFFFF0000);
      set_bank(3, 32'h00FF00FF);
      strobe();
      rd("R5 level high and low", 3, 4, 32'hFF0000FF);
      wreg(3, 4, 32'hFFFFFFFF);
      rd("R5 cleared", 3, 4, 32'h0);
      strobe();
      rd("R5 level sets again", 3, 4, 32'hFF0000FF);
      wreg(3, 4, 32'hFFFFFFFF);

      // R7: input motion without strobe
      for (int k = 0; k < 6; k++) begin
         set_bank(1, (k % 2) ? 32'hFFFFFFFF : 32'h0);
         set_bank(3, (k % 2) ? 32'h0 : 32'hFFFFFFFF);
         tick(1'b0, 1'b0, 0, 0, '0);
      end
      rd("R7 no strobe bank1", 1, 4, 32'h0);
      rd("R7 no strobe bank3", 3, 4, 32'h0);
      set_bank(1, 32'h0);
      set_bank(3, 32'h00FF00FF);
      // config write together with a strobe applies later
      tick(1'b1, 1'b1, 1, 2, 32'hFFFFFFFF);
      rd("R7 same-cycle config not used", 1, 4, 32'h0);
      rd("R5 level during R7 strobe", 3, 4, 32'hFF0000FF);
      strobe();
      rd("R7 config used on next strobe", 1, 4, 32'hFFFFFFFF);
      wreg(1, 2, 32'h0);
      wreg(1, 4, 32'hFFFFFFFF);

      // R8: write 0 and single-bit clears
      wreg(3, 4, 32'h0);
      rd("R8 zero write keeps", 3, 4, 32'hFF0000FF);
      wreg(3, 4, 32'h00000001);
      rd("R8 single bit clear", 3, 4, 32'hFF0000FE);
      wreg(0, 4, 32'hFFFFFFFF);
      rd("R8 other bank untouched", 3, 4, 32'hFF0000FE);

      // R9: set beats clear
      tick(1'b1, 1'b1, 3, 4, 32'hFFFFFFFF);
      rd("R9 event outranks clear", 3, 4, 32'hFF0000FF);

      // R10: enables gate irq only
      chk("R10 disabled flag no irq", {31'b0, irq}, 32'd0);
      wreg(3, 0, 32'h00000100);
      chk("R10 enable on clear bit", {31'b0, irq}, 32'd0);
      wreg(3, 0, 32'h80000000);
      chk("R10 enabled flag irq", {31'b0, irq}, 32'd1);
      wreg(3, 2, 32'h0);
      wreg(3, 4, 32'h80000000);
      chk("R10 cleared irq low", {31'b0, irq}, 32'd0);
      rd("R10 flag kept without enable", 3, 4, 32'h7F0000FF);
      wreg(0, 0, 32'h00010000);
      set_bank(0, 32'hFFFE0000);
      strobe();
      set_bank(0, 32'hFFFFFFFF);
      strobe();
      chk("R10 irq from bank0", {31'b0, irq}, 32'd1);
      wreg(0, 4, 32'h00010000);
      chk("R10 irq drops", {31'b0, irq}, 32'd0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired (all requirements) actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule